// File: doc/BRIEF.md
# Camera Capture Sequencer with Interrupt Flags

This block decides which frames coming from a camera pixel path are written to memory. It offers two capture modes. Still capture takes exactly one frame for each software request. Video capture takes every frame for as long as its enable is held. The block only starts a capture at a frame start. It only ends one after the last pixel of a frame has been written. Because of this, memory never holds a partial frame.

On every vsync the block also copies the software buffer-address register into the address that the write path uses. A write to that register made after a vsync therefore takes effect on the following frame.

The block keeps four sticky interrupt flags:
- vsync
- overflow still present at the end of horizontal blanking
- protocol error
- overflow of FIFO 2

Software clears a flag by writing 1 to its bit. A single interrupt line is raised while any flag whose enable bit is set is high.

The pixel path sends the block one-cycle strobes for vsync, end of field, end of horizontal blanking and protocol errors. It also supplies a field identity and one overflow level per FIFO. In interlaced planar 4:2:0 mode a frame is made of two fields. In that mode:
- a frame starts at the vsync of field 1
- a frame ends at the end of field 2

In every other mode each field counts as a whole frame.

Top module: `cam_capture_ctrl`

## Requirements
- R1: When video enable is high at a frame start and nothing is being captured, the video status bit is set in the cycle after that frame start. Enabling video in the middle of a frame leaves the status bit at 0 until the next frame start.
- R2: When video enable is low at a frame end, the video status bit clears in the cycle after that frame end. While video capture runs, lowering video enable in the middle of a frame has no effect until that frame ends.
- R3: A still request (a one-cycle strobe) is held pending. At the next frame start where video is not taken, the still status bit is set. It clears after the frame end of that same frame. Exactly one frame is captured for each request.
- R4: On every vsync the frame address output takes the buffer-address input, visible from the next cycle. Between vsyncs the frame address output holds its value whatever the buffer-address input does.
- R5: Every vsync strobe sets the vsync flag (flag bit 7).
- R6: The horizontal-blank overflow flag (flag bit 6) is set only by a horizontal-blank-end strobe that arrives while all three FIFO overflow inputs are high.
- R7: Field identity is 0 for field 1 and 1 for field 2. With interlaced planar mode high, a frame start is a vsync with field identity 0 and a frame end is a field-end strobe with field identity 1. With the mode low, every vsync is a frame start and every field-end strobe is a frame end.
- R8: The flag and enable layout is as follows. Bit 7 is vsync, bit 6 is horizontal-blank overflow, bit 5 is protocol error and bit 4 is FIFO 2 overflow. The FIFO 2 flag is set in any cycle where the FIFO 2 overflow input is high. All other flag bits read 0.
- R9: A flag stays set until a clear vector with 1 at its bit is applied, and then reads 0 from the next cycle. If the flag is set and cleared in the same cycle, the set wins.
- R10: The interrupt output is high exactly when some flag bit and its enable bit are both 1.
- R11: Pixel write enable is high exactly while the still or the video status bit is high.
- R12: When video enable is high at a frame start, video is taken and a pending still request stays pending. That still request is served at the first frame start after video capture has ended and video enable is low.
- R13: While reset is low, and for two clock cycles after it rises, the status bits, the frame address, the flags, the interrupt line and pixel write enable are all 0, and any pending still request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| vsync_i | input | 1 | Field start strobe |
| field_id_i | input | 1 | Field identity, 0 = field 1, 1 = field 2, valid with vsync and field-end strobes |
| field_end_i | input | 1 | Strobe on the last pixel of a field |
| hblank_end_i | input | 1 | Strobe at the end of horizontal blanking |
| fifo_ovf_i | input | 3 | Overflow level of each pixel FIFO |
| proto_err_i | input | 1 | Protocol error strobe |
| ilp_mode_i | input | 1 | 1 = interlaced input with planar 4:2:0 output |
| still_req_i | input | 1 | Still capture request strobe |
| video_en_i | input | 1 | Video capture enable |
| buf_addr_i | input | 32 | Software buffer-address register |
| irq_en_i | input | 32 | Interrupt enable register |
| irq_clr_i | input | 32 | Write-1-to-clear strobe vector for the flags |
| vcap_sta_o | output | 1 | Video capture in progress |
| scap_sta_o | output | 1 | Still capture in progress |
| pix_we_o | output | 1 | Pixel write enable |
| frame_addr_o | output | 32 | Buffer address used by the current frame |
| irq_flags_o | output | 32 | Sticky interrupt flags |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions rely on the pixel path behaving sanely:
- The vsync, field-end and horizontal-blank-end strobes last one cycle.
- A frame end and a frame start never fall in the same cycle.
- Field identity is stable whenever one of those strobes is present.

The stimulus is built from whole fields. Each field is a vsync cycle, then line cycles carrying blanking strobes, then a separate field-end cycle. Software actions (requests, enables, address writes, clears) are placed on line cycles in the middle of a frame, or in the same cycle as a boundary on purpose, and never break that framing.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned NUM_EVT    = 4;
  localparam int unsigned FLAG_BASE  = 4;   // lowest flag bit
  // event index -> flag bit FLAG_BASE + index
  localparam int unsigned EV_FIFO2   = 0;
  localparam int unsigned EV_PERR    = 1;
  localparam int unsigned EV_HBOVF   = 2;
  localparam int unsigned EV_VSYNC   = 3;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_STILL = 2'd1,
    CAP_VIDEO = 2'd2
  } cap_state_e;
endpackage

// File: rtl/cam_frame_bound.sv
module cam_frame_bound (
  input  logic vsync_i,
  input  logic field_end_i,
  input  logic field_id_i,
  input  logic ilp_mode_i,
  output logic frame_start_o,
  output logic frame_end_o
);
  // In interlaced planar mode a frame spans field 1 then field 2.
  always_comb begin
    frame_start_o = vsync_i     && (!ilp_mode_i || !field_id_i);
    frame_end_o   = field_end_i && (!ilp_mode_i ||  field_id_i);
  end
endmodule

// File: rtl/cam_capture_seq.sv
module cam_capture_seq
  import cam_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start_i,
  input  logic frame_end_i,
  input  logic still_req_i,
  input  logic video_en_i,
  output logic vcap_o,
  output logic scap_o
);
  cap_state_e st_q, st_d;
  logic       pend_q, pend_d;
  logic       st_en, pend_en;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q | still_req_i;
    unique case (st_q)
      CAP_IDLE: begin
        if (frame_start_i) begin
          if (video_en_i) begin
            st_d = CAP_VIDEO;          // video wins, still stays pending
          end else if (pend_d) begin
            st_d   = CAP_STILL;
            pend_d = 1'b0;
          end
        end
      end
      CAP_STILL: begin
        if (frame_end_i) st_d = CAP_IDLE;
      end
      CAP_VIDEO: begin
        if (frame_end_i && !video_en_i) st_d = CAP_IDLE;
      end
      default: st_d = CAP_IDLE;
    endcase
  end

  assign st_en   = frame_start_i | frame_end_i;
  assign pend_en = frame_start_i | still_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAP_IDLE;
      pend_q <= 1'b0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign vcap_o = (st_q == CAP_VIDEO);
  assign scap_o = (st_q == CAP_STILL);

  p_vcap_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcap_o) |-> $past(frame_start_i && video_en_i));
  p_vcap_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcap_o) |-> $past(frame_end_i && !video_en_i));
  p_still_one_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scap_o && frame_end_i) |=> !scap_o);
  p_scap_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scap_o) |-> $past(frame_start_i && !video_en_i));
  p_video_priority_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && video_en_i && !vcap_o && !scap_o) |=> (vcap_o && !scap_o));
endmodule

// File: rtl/cam_addr_latch.sv
module cam_addr_latch #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  output logic [ADDR_W-1:0] frame_addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (vsync_i) addr_q <= buf_addr_i;
  end

  assign frame_addr_o = addr_q;

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_i |=> $stable(frame_addr_o));
  p_addr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> (frame_addr_o == $past(buf_addr_i)));
endmodule

// File: rtl/cam_irq_flags.sv
module cam_irq_flags
  import cam_cap_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [W-1:0]       clr_i,
  input  logic [W-1:0]       en_i,
  output logic [W-1:0]       flags_o,
  output logic               irq_o
);
  localparam int unsigned TOP = FLAG_BASE + NUM_EVT;

  logic [NUM_EVT-1:0] flg_q, flg_d, flg_en;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    always_comb begin
      flg_en[i] = evt_i[i] | clr_i[FLAG_BASE+i];
      flg_d[i]  = evt_i[i] | (flg_q[i] & ~clr_i[FLAG_BASE+i]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flg_q[i] <= 1'b0;
      else if (flg_en[i]) flg_q[i] <= flg_d[i];
    end
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[i] && !clr_i[FLAG_BASE+i]) |=> flg_q[i]);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flg_q[i]);
  end

  always_comb begin
    flags_o                 = '0;
    flags_o[TOP-1:FLAG_BASE] = flg_q;
  end

  assign irq_o = |(flags_o & en_i);

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flg_q != '0));
endmodule

// File: rtl/cam_capture_ctrl.sv
module cam_capture_ctrl
  import cam_cap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_FIFO = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vsync_i,
  input  logic                field_id_i,
  input  logic                field_end_i,
  input  logic                hblank_end_i,
  input  logic [NUM_FIFO-1:0] fifo_ovf_i,
  input  logic                proto_err_i,
  input  logic                ilp_mode_i,
  input  logic                still_req_i,
  input  logic                video_en_i,
  input  logic [ADDR_W-1:0]   buf_addr_i,
  input  logic [REG_W-1:0]    irq_en_i,
  input  logic [REG_W-1:0]    irq_clr_i,
  output logic                vcap_sta_o,
  output logic                scap_sta_o,
  output logic                pix_we_o,
  output logic [ADDR_W-1:0]   frame_addr_o,
  output logic [REG_W-1:0]    irq_flags_o,
  output logic                irq_o
);
  localparam int unsigned F2_IDX = 2;

  // reset: asserted asynchronously, released after two clocks
  logic rs_meta_q, rs_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end

  logic frame_start, frame_end;
  logic [NUM_EVT-1:0] evt;

  cam_frame_bound u_bound (
    .vsync_i      (vsync_i),
    .field_end_i  (field_end_i),
    .field_id_i   (field_id_i),
    .ilp_mode_i   (ilp_mode_i),
    .frame_start_o(frame_start),
    .frame_end_o  (frame_end)
  );

  cam_capture_seq u_seq (
    .clk          (clk),
    .rst_n        (rs_sync_q),
    .frame_start_i(frame_start),
    .frame_end_i  (frame_end),
    .still_req_i  (still_req_i),
    .video_en_i   (video_en_i),
    .vcap_o       (vcap_sta_o),
    .scap_o       (scap_sta_o)
  );

  cam_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst_n       (rs_sync_q),
    .vsync_i     (vsync_i),
    .buf_addr_i  (buf_addr_i),
    .frame_addr_o(frame_addr_o)
  );

  always_comb begin
    evt           = '0;
    evt[EV_FIFO2] = fifo_ovf_i[F2_IDX];
    evt[EV_PERR]  = proto_err_i;
    evt[EV_HBOVF] = hblank_end_i & (&fifo_ovf_i);
    evt[EV_VSYNC] = vsync_i;
  end

  cam_irq_flags #(.W(REG_W)) u_irq (
    .clk    (clk),
    .rst_n  (rs_sync_q),
    .evt_i  (evt),
    .clr_i  (irq_clr_i),
    .en_i   (irq_en_i),
    .flags_o(irq_flags_o),
    .irq_o  (irq_o)
  );

  assign pix_we_o = vcap_sta_o | scap_sta_o;

  p_hb_ovf_r6: assert property (@(posedge clk) disable iff (!rs_sync_q)
    $rose(irq_flags_o[6]) |-> $past(hblank_end_i && (&fifo_ovf_i)));
  p_vs_flag_r5: assert property (@(posedge clk) disable iff (!rs_sync_q)
    vsync_i |=> irq_flags_o[7]);
  p_we_idle_r11: assert property (@(posedge clk) disable iff (!rs_sync_q)
    (!vcap_sta_o && !scap_sta_o) |-> !pix_we_o);
  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rs_sync_q)
    (irq_flags_o[3:0] == 4'h0) && (irq_flags_o[31:8] == 24'h0));
endmodule

// File: tb/tb_cam_capture_ctrl.sv
module tb_cam_capture_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync_i = 0, field_id_i = 0, field_end_i = 0, hblank_end_i = 0;
  logic [2:0]  fifo_ovf_i = 0;
  logic        proto_err_i = 0, ilp_mode_i = 0, still_req_i = 0, video_en_i = 0;
  logic [31:0] buf_addr_i = 0, irq_en_i = 0, irq_clr_i = 0;
  logic        vcap_sta_o, scap_sta_o, pix_we_o, irq_o;
  logic [31:0] frame_addr_o, irq_flags_o;

  always #4 clk = ~clk;   // 125 MHz

  cam_capture_ctrl dut (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .field_id_i(field_id_i),
    .field_end_i(field_end_i), .hblank_end_i(hblank_end_i), .fifo_ovf_i(fifo_ovf_i),
    .proto_err_i(proto_err_i), .ilp_mode_i(ilp_mode_i), .still_req_i(still_req_i),
    .video_en_i(video_en_i), .buf_addr_i(buf_addr_i), .irq_en_i(irq_en_i),
    .irq_clr_i(irq_clr_i), .vcap_sta_o(vcap_sta_o), .scap_sta_o(scap_sta_o),
    .pix_we_o(pix_we_o), .frame_addr_o(frame_addr_o), .irq_flags_o(irq_flags_o),
    .irq_o(irq_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string ctx = "R13 reset";

  // behavioural reference: 0 idle, 1 still, 2 video
  int          m_mode = 0;
  bit          m_pend = 0;
  logic [31:0] m_addr = 0, m_flags = 0, m_set;
  int          m_rcnt = 0;   // clocks seen since reset release
  bit          fs, fe, pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_addr = 0; m_flags = 0; m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      fs   = vsync_i && (!ilp_mode_i || field_id_i == 1'b0);
      fe   = field_end_i && (!ilp_mode_i || field_id_i == 1'b1);
      pend = m_pend || still_req_i;
      if (m_mode == 0 && fs) begin
        if (video_en_i) m_mode = 2;
        else if (pend) begin m_mode = 1; pend = 0; end
      end else if (m_mode == 1 && fe) m_mode = 0;
      else if (m_mode == 2 && fe && !video_en_i) m_mode = 0;
      m_pend = pend;
      if (vsync_i) m_addr = buf_addr_i;
      m_set = 0;
      m_set[7] = vsync_i;
      m_set[6] = hblank_end_i && (fifo_ovf_i == 3'b111);
      m_set[5] = proto_err_i;
      m_set[4] = fifo_ovf_i[2];
      m_flags = (m_flags & ~irq_clr_i) | m_set;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 R2 R12 vcap", {31'd0, vcap_sta_o}, {31'd0, m_mode == 2});
    chk("R3 R12 scap",    {31'd0, scap_sta_o}, {31'd0, m_mode == 1});
    chk("R11 pix_we",     {31'd0, pix_we_o},   {31'd0, m_mode != 0});
    chk("R4 frame_addr",  frame_addr_o, m_addr);
    chk("R5 R6 R8 R9 flags", irq_flags_o, m_flags);
    chk("R10 irq", {31'd0, irq_o}, {31'd0, |(m_flags & irq_en_i)});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    vsync_i = 0; field_end_i = 0; hblank_end_i = 0; proto_err_i = 0;
    still_req_i = 0; irq_clr_i = 0;
  endtask

  task automatic field(bit fid, int lines);
    vsync_i = 1; field_id_i = fid; tick();
    for (int l = 0; l < lines; l++) begin hblank_end_i = (l % 2 == 1); tick(); end
    field_end_i = 1; field_id_i = fid; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); compare_all();
    @(negedge clk); rst_n = 1; compare_all();
    tick(); tick();            // R13 synchroniser delay
    tick();
    // R1: enable in the middle of a frame, start waits for next vsync
    ctx = "R1 mid-frame enable";
    vsync_i = 1; tick(); tick();
    video_en_i = 1; tick(); tick();
    field_end_i = 1; tick();
    field(0, 4); field(0, 4);
    // R2: disable mid-frame, stop at frame end
    ctx = "R2 disable mid-frame";
    vsync_i = 1; tick(); tick(); video_en_i = 0; tick(); tick();
    field_end_i = 1; tick(); field(0, 3);
    // R3: still request, single frame
    ctx = "R3 still";
    still_req_i = 1; tick(); field(0, 3); field(0, 3);
    // R12: video priority over a pending still
    ctx = "R12 priority";
    still_req_i = 1; video_en_i = 1; tick();
    field(0, 3); vsync_i = 1; tick(); video_en_i = 0; tick(); field_end_i = 1; tick();
    field(0, 3); field(0, 3);
    // R4: address writes land on the next frame only
    ctx = "R4 address";
    buf_addr_i = 32'h1000_0000; field(0, 2);
    vsync_i = 1; tick(); buf_addr_i = 32'h2000_0040; tick(); tick();
    field_end_i = 1; tick(); field(0, 2);
    buf_addr_i = 32'hDEAD_BEE0; vsync_i = 1; tick();
    // R6 R8: overflow patterns
    ctx = "R6 R8 overflow";
    irq_clr_i = 32'hFFFF_FFFF; tick();
    fifo_ovf_i = 3'b011; hblank_end_i = 1; tick();
    fifo_ovf_i = 3'b111; tick();
    hblank_end_i = 1; tick();
    fifo_ovf_i = 3'b000; tick();
    proto_err_i = 1; tick();
    // R9 R10: clears, set-wins, enables
    ctx = "R9 R10 clear and enable";
    irq_en_i = 32'h0000_0020; tick();
    irq_clr_i = 32'h0000_0020; tick();
    irq_en_i = 32'h0000_00F0; irq_clr_i = 32'h0000_0080; vsync_i = 1; tick();
    irq_clr_i = 32'h0000_00D0; tick(); tick();
    irq_en_i = 32'hFFFF_FF0F; proto_err_i = 1; tick();
    // R7: interlaced planar mode
    ctx = "R7 interlaced planar";
    ilp_mode_i = 1; video_en_i = 1;
    field(1, 2); field(0, 2); field(1, 2);
    field(0, 2); vsync_i = 1; field_id_i = 1; tick(); video_en_i = 0; tick();
    field_end_i = 1; field_id_i = 1; tick();
    still_req_i = 1; tick(); field(1, 2); field(0, 2); field(1, 2); field(0, 2);
    ilp_mode_i = 0;
    // R13: reset in the middle of a capture
    ctx = "R13 reset mid capture";
    video_en_i = 1; still_req_i = 1; field(0, 2); vsync_i = 1; tick();
    rst_n = 0; tick(); rst_n = 1; video_en_i = 0; tick(); tick(); field(0, 2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule